// File: doc/BRIEF.md
# Page Pointer Walker

The block turns a transfer descriptor into an ordered stream of (address, length) segments. The descriptor has a first page pointer, a second page pointer and a byte count. The first pointer supplies the first segment, which runs from the pointer to the end of its page or to the end of the transfer, whichever comes first. If at most one page is left after that, the second pointer is the final segment. If more is left, the second pointer is the address of a list of 64-bit page addresses in memory. The block fetches that list through a read request port and receives its words one per response beat. When the last slot of a full list is reached while more than one page still remains, that slot points to the next list. Every list word is checked before it is used, and any bad pointer ends the walk with an invalid-field status that is marked as not retryable.

One pulse on `start` latches the descriptor and the page-size selector. Segments are handed out on a valid/ready pair. A single-cycle `done` pulse carries the final status. The state machine has these states:
- `ST_IDLE` goes to `ST_LOAD` on start.
- `ST_LOAD` goes to `ST_DONE` if the first pointer is zero, and otherwise to `ST_SEG_HEAD`.
- `ST_SEG_HEAD` leaves on a segment handshake:
  - to `ST_DONE` if nothing remains or the second pointer is bad;
  - to `ST_SEG_DIRECT` if at most one page remains;
  - to `ST_LIST_REQ` otherwise.
- `ST_SEG_DIRECT` goes to `ST_DONE` on a segment handshake.
- `ST_LIST_REQ` goes to `ST_LIST_BEAT` on a request handshake.
- `ST_LIST_BEAT` leaves on a response beat:
  - to `ST_SEG_LIST` for a data entry;
  - to `ST_LIST_REQ` for a chain entry;
  - to `ST_DRAIN` or `ST_DONE` for a bad entry.
- `ST_SEG_LIST` goes to `ST_LIST_BEAT` after a segment handshake, or to `ST_DONE` once nothing remains.
- `ST_DRAIN` discards the unread beats of the burst and then goes to `ST_DONE`.
- `ST_DONE` returns to `ST_IDLE`.

Top module: `page_list_walker`

## Requirements
- R1: The first segment starts at the first pointer. Its length is the smaller of the byte count and (page size minus the first pointer modulo page size).
- R2: A zero first pointer produces no segment and no request. It ends with `done` high and both `done_err` and `done_no_retry` high.
- R3: If the bytes left after the first segment are nonzero and at most one page, the second pointer is emitted as the last segment, carrying all of those bytes. A second pointer that is zero or has any page-offset bit set instead ends the walk with the error status.
- R4: If more than one page is left, a read request is issued with `rd_req_addr` equal to the list address and `rd_req_count` equal to min(page size / 8, ceil(remaining / page size)). A zero second pointer ends the walk with the error status before any request.
- R5: Each list word that is not a chain pointer yields one segment. The segment address is the word and its length is min(remaining, page size). Segments come out in slot order.
- R6: When the word in slot page size/8 - 1 arrives while more than one page remains, the word is the address of the next list. A new request for that list is issued by the rule of R4, and the walk restarts at slot 0 of the new list.
- R7: A list word that is zero or has any page-offset bit set, chain pointers included, ends the walk with the error status. All response beats still owed by that request are accepted before `done`.
- R8: Page size is 2^(BASE_SHIFT + `page_sel`), with `page_sel` latched at start.
- R9: While a segment or a request is offered and not accepted, it stays offered with stable address, length and count. At most one of segment valid, request valid and response ready is high in any cycle.
- R10: After reset and between walks no segment, request or `done` is driven. `done` is a one-cycle pulse with error flags low on success, and no segment or request is offered in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled when idle) |
| ptr_first | input | ADDR_W | First page pointer |
| ptr_second | input | ADDR_W | Second pointer: direct page or list address |
| xfer_bytes | input | LEN_W | Transfer length in bytes |
| page_sel | input | SEL_W | Page size selector |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | ADDR_W | Segment address |
| seg_len | output | LEN_W | Segment length in bytes |
| rd_req_valid | output | 1 | List read request offered |
| rd_req_ready | input | 1 | List read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the first list word |
| rd_req_count | output | LEN_W | Number of 64-bit words requested |
| rd_rsp_valid | input | 1 | Response beat present |
| rd_rsp_ready | output | 1 | Response beat accepted |
| rd_rsp_data | input | ADDR_W | One list word, little-endian |
| done | output | 1 | Walk finished (one cycle) |
| done_err | output | 1 | Invalid-field error status |
| done_no_retry | output | 1 | Do-not-retry flag of the status |

## Verification
The bench is built with a 32-byte base page so that lists of 4, 8 and 16 entries can be swept. For each of those page sizes it varies the first-pointer offset between aligned, odd, mid-page and last-word values. Transfer lengths step in three-quarter-page increments, which covers:
- a single segment;
- a direct second page;
- a list that ends before its last slot;
- a walk that crosses one or more chain pointers.

Backpressure is applied at random on the segment, request and response handshakes for one of the page sizes. This separates stall handling from the ordering of the walk. Targeted corruptions each hit one check:
- a zero first pointer;
- a zero or misaligned direct pointer;
- a zero list address;
- a zero entry in the middle of a burst;
- a misaligned chain pointer;
- a misaligned entry in a chained list.

A clean walk follows the corruptions and shows that the unread beats were drained.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEG_HEAD,
        ST_SEG_DIRECT,
        ST_LIST_REQ,
        ST_LIST_BEAT,
        ST_SEG_LIST,
        ST_DRAIN,
        ST_DONE
    } pgw_state_t;
endpackage

// File: rtl/pgw_geom.sv
`timescale 1ns/1ps
// Page geometry derived from the latched selector.
module pgw_geom #(
    parameter int LEN_W      = 32,
    parameter int SEL_W      = 4,
    parameter int BASE_SHIFT = 12
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] page_bytes,
    output logic [LEN_W-1:0] page_mask,
    output logic [LEN_W-1:0] slots,
    output logic [LEN_W-1:0] pages_left
);
    localparam int SH_W = $clog2(BASE_SHIFT + (1 << SEL_W));

    logic [SH_W-1:0] shift;

    always_comb begin
        shift      = SH_W'(BASE_SHIFT) + SH_W'(sel);
        page_bytes = LEN_W'(1) << shift;
        page_mask  = page_bytes - LEN_W'(1);
        slots      = page_bytes >> 3;
        // ceiling of remain / page_bytes without a carry bit
        pages_left = (remain >> shift) + LEN_W'(|(remain & page_mask));
    end
endmodule

// File: rtl/pgw_ptr_check.sv
`timescale 1ns/1ps
// Flags a page pointer that is zero or not page aligned.
module pgw_ptr_check #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [LEN_W-1:0]  page_mask,
    output logic              bad
);
    always_comb begin
        bad = (ptr == '0) || (|(ptr & ADDR_W'(page_mask)));
    end
endmodule

// File: rtl/page_list_walker.sv
`timescale 1ns/1ps
module page_list_walker
    import pgw_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int LEN_W      = 32,
    parameter int SEL_W      = 4,
    parameter int BASE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] ptr_first,
    input  logic [ADDR_W-1:0] ptr_second,
    input  logic [LEN_W-1:0]  xfer_bytes,
    input  logic [SEL_W-1:0]  page_sel,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [LEN_W-1:0]  rd_req_count,
    input  logic              rd_rsp_valid,
    output logic              rd_rsp_ready,
    input  logic [ADDR_W-1:0] rd_rsp_data,
    output logic              done,
    output logic              done_err,
    output logic              done_no_retry
);
    pgw_state_t state, state_nx;

    logic [SEL_W-1:0]  sel_r;
    logic [ADDR_W-1:0] first_r, second_r, list_addr, seg_addr_r;
    logic [LEN_W-1:0]  remain, seg_len_r, slot, beats;
    logic              err_r;

    logic [LEN_W-1:0]  page_bytes, page_mask, slots, pages_left;
    logic [LEN_W-1:0]  head_room, head_len, list_len, req_cnt;
    logic              second_bad, entry_bad, is_chain;
    logic              seg_fire, req_fire, beat_fire;

    pgw_geom #(.LEN_W(LEN_W), .SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_geom (
        .sel        (sel_r),
        .remain     (remain),
        .page_bytes (page_bytes),
        .page_mask  (page_mask),
        .slots      (slots),
        .pages_left (pages_left)
    );

    pgw_ptr_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk_second (
        .ptr       (second_r),
        .page_mask (page_mask),
        .bad       (second_bad)
    );

    pgw_ptr_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk_entry (
        .ptr       (rd_rsp_data),
        .page_mask (page_mask),
        .bad       (entry_bad)
    );

    always_comb begin
        head_room = page_bytes - (first_r[LEN_W-1:0] & page_mask);
        head_len  = (remain < head_room) ? remain : head_room;
        list_len  = (remain < page_bytes) ? remain : page_bytes;
        req_cnt   = (pages_left < slots) ? pages_left : slots;
        is_chain  = (slot == slots - LEN_W'(1)) && (remain > page_bytes);
        seg_fire  = seg_valid && seg_ready;
        req_fire  = rd_req_valid && rd_req_ready;
        beat_fire = rd_rsp_valid && rd_rsp_ready;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start) state_nx = ST_LOAD;
            ST_LOAD:       state_nx = (first_r == '0) ? ST_DONE : ST_SEG_HEAD;
            ST_SEG_HEAD:
                if (seg_fire) begin
                    if (remain == '0)                state_nx = ST_DONE;
                    else if (remain <= page_bytes)   state_nx = second_bad ? ST_DONE : ST_SEG_DIRECT;
                    else if (second_r == '0)         state_nx = ST_DONE;
                    else                             state_nx = ST_LIST_REQ;
                end
            ST_SEG_DIRECT: if (seg_fire) state_nx = ST_DONE;
            ST_LIST_REQ:   if (req_fire) state_nx = ST_LIST_BEAT;
            ST_LIST_BEAT:
                if (beat_fire) begin
                    if (entry_bad)     state_nx = (beats > LEN_W'(1)) ? ST_DRAIN : ST_DONE;
                    else if (is_chain) state_nx = ST_LIST_REQ;
                    else               state_nx = ST_SEG_LIST;
                end
            ST_SEG_LIST:
                if (seg_fire) state_nx = (remain == '0) ? ST_DONE : ST_LIST_BEAT;
            ST_DRAIN:
                if (beat_fire && beats == LEN_W'(1)) state_nx = ST_DONE;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_r      <= '0;
            first_r    <= '0;
            second_r   <= '0;
            list_addr  <= '0;
            seg_addr_r <= '0;
            seg_len_r  <= '0;
            remain     <= '0;
            slot       <= '0;
            beats      <= '0;
            err_r      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:
                    if (start) begin
                        sel_r    <= page_sel;
                        first_r  <= ptr_first;
                        second_r <= ptr_second;
                        remain   <= xfer_bytes;
                        err_r    <= 1'b0;
                    end
                ST_LOAD:
                    if (first_r == '0) begin
                        err_r <= 1'b1;
                    end else begin
                        seg_addr_r <= first_r;
                        seg_len_r  <= head_len;
                        remain     <= remain - head_len;
                    end
                ST_SEG_HEAD:
                    if (seg_fire && remain != '0) begin
                        if (remain <= page_bytes) begin
                            if (second_bad) begin
                                err_r <= 1'b1;
                            end else begin
                                seg_addr_r <= second_r;
                                seg_len_r  <= remain;
                                remain     <= '0;
                            end
                        end else if (second_r == '0) begin
                            err_r <= 1'b1;
                        end else begin
                            list_addr <= second_r;
                        end
                    end
                ST_LIST_REQ:
                    if (req_fire) begin
                        beats <= req_cnt;
                        slot  <= '0;
                    end
                ST_LIST_BEAT:
                    if (beat_fire) begin
                        beats <= beats - LEN_W'(1);
                        if (entry_bad) begin
                            err_r <= 1'b1;
                        end else if (is_chain) begin
                            list_addr <= rd_rsp_data;
                        end else begin
                            seg_addr_r <= rd_rsp_data;
                            seg_len_r  <= list_len;
                            remain     <= remain - list_len;
                            slot       <= slot + LEN_W'(1);
                        end
                    end
                ST_DRAIN:
                    if (beat_fire) beats <= beats - LEN_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        seg_valid     = 1'b0;
        rd_req_valid  = 1'b0;
        rd_rsp_ready  = 1'b0;
        done          = 1'b0;
        unique case (state)
            ST_SEG_HEAD, ST_SEG_DIRECT, ST_SEG_LIST: seg_valid    = 1'b1;
            ST_LIST_REQ:                             rd_req_valid = 1'b1;
            ST_LIST_BEAT, ST_DRAIN:                  rd_rsp_ready = 1'b1;
            ST_DONE:                                 done         = 1'b1;
            default: ;
        endcase
        seg_addr      = seg_addr_r;
        seg_len       = seg_len_r;
        rd_req_addr   = list_addr;
        rd_req_count  = req_cnt;
        done_err      = done && err_r;
        done_no_retry = done && err_r;
    end
endmodule

// File: rtl/pgw_checker.sv
`timescale 1ns/1ps
module pgw_checker #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic [LEN_W-1:0]  rd_req_count,
    input logic              rd_rsp_ready,
    input logic              done
);
    assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_count));

    assert_one_channel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seg_valid, rd_req_valid, rd_rsp_ready}));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !seg_valid && !rd_req_valid && !rd_rsp_ready);

    assert_req_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> rd_req_count != '0 && rd_req_addr != '0);
endmodule

bind page_list_walker pgw_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_pgw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .seg_valid    (seg_valid),
    .seg_ready    (seg_ready),
    .seg_addr     (seg_addr),
    .seg_len      (seg_len),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_req_count (rd_req_count),
    .rd_rsp_ready (rd_rsp_ready),
    .done         (done)
);

// File: tb/page_list_walker_tb.sv
`timescale 1ns/1ps
module page_list_walker_tb;
    localparam int BS = 5;  // 32-byte base page in the bench build

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] ptr_first = '0, ptr_second = '0;
    logic [31:0] xfer_bytes = '0;
    logic [3:0]  page_sel = '0;
    logic        seg_valid, seg_ready = 1'b0;
    logic [63:0] seg_addr;
    logic [31:0] seg_len;
    logic        rd_req_valid, rd_req_ready = 1'b0;
    logic [63:0] rd_req_addr;
    logic [31:0] rd_req_count;
    logic        rd_rsp_valid = 1'b0, rd_rsp_ready;
    logic [63:0] rd_rsp_data = '0;
    logic        done, done_err, done_no_retry;

    always #5 clk = ~clk;  // 100 MHz

    page_list_walker #(.ADDR_W(64), .LEN_W(32), .SEL_W(4), .BASE_SHIFT(BS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ptr_first(ptr_first), .ptr_second(ptr_second),
        .xfer_bytes(xfer_bytes), .page_sel(page_sel),
        .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_count(rd_req_count),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
        .rd_rsp_data(rd_rsp_data),
        .done(done), .done_err(done_err), .done_no_retry(done_no_retry)
    );

    int checks = 0;
    int errors = 0;

    logic [63:0] mem [0:2047];
    function automatic int idx(input logic [63:0] a);
        return int'((a >> 3) & 64'd2047);
    endfunction

    // observed
    logic [63:0] got_addr [0:63];
    int          got_len  [0:63];
    int          got_n;
    logic [63:0] got_rq_addr [0:31];
    int          got_rq_cnt  [0:31];
    int          got_rq;
    bit          got_done, got_err, got_nr;
    // expected
    logic [63:0] exp_addr [0:63];
    int          exp_len  [0:63];
    int          exp_n;
    logic [63:0] exp_rq_addr [0:31];
    int          exp_rq_cnt  [0:31];
    int          exp_rq;
    bit          exp_err;

    bit          bp_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          pend_n = 0;
    logic [63:0] pend_addr = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    // responder: drive at negedge, sample 1 ns later
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        seg_ready    = !bp_on || lfsr[0] || lfsr[2];
        rd_req_ready = !bp_on || lfsr[1] || lfsr[3];
        rd_rsp_valid = (pend_n > 0) && (!bp_on || lfsr[4] || lfsr[5]);
        rd_rsp_data  = mem[idx(pend_addr)];
        #1;
        if (rd_req_valid && rd_req_ready && got_rq < 32) begin
            got_rq_addr[got_rq] = rd_req_addr;
            got_rq_cnt[got_rq]  = int'(rd_req_count);
            got_rq++;
            pend_n    = int'(rd_req_count);
            pend_addr = rd_req_addr;
        end
        if (rd_rsp_valid && rd_rsp_ready) begin
            pend_n--;
            pend_addr += 64'd8;
        end
        if (seg_valid && seg_ready && got_n < 64) begin
            got_addr[got_n] = seg_addr;
            got_len[got_n]  = int'(seg_len);
            got_n++;
        end
        if (done) begin
            got_done = 1'b1;
            got_err  = done_err;
            got_nr   = done_no_retry;
        end
    end

    task automatic fill_mem(input int sel);
        int psz = 1 << (BS + sel);
        int epp = psz / 8;
        for (int i = 0; i < 2048; i++) mem[i] = 64'h0;
        for (int j = 0; j < 24; j++)
            for (int k = 0; k < epp; k++)
                mem[idx(64'h1000 + 64'(j * 512 + k * 8))] = (k == epp - 1) ?
                    64'h1000 + 64'((j + 1) * 512) :
                    64'h40_0000_0000 + (64'(j * 16 + k + 1) << (BS + sel));
    endtask

    // reference walk computed from the requirements
    task automatic ref_walk(input logic [63:0] a, input logic [63:0] b, input int len, input int sel);
        int          psz = 1 << (BS + sel);
        int          epp = psz / 8;
        int          rem, l, cnt, i;
        logic [63:0] la, e;
        bit          more;
        exp_n = 0; exp_rq = 0; exp_err = 1'b0;
        if (a == 0) begin exp_err = 1'b1; return; end
        l = psz - int'(a & 64'(psz - 1));
        if (len < l) l = len;
        exp_addr[exp_n] = a; exp_len[exp_n] = l; exp_n++;
        rem = len - l;
        if (rem == 0) return;
        if (rem <= psz) begin
            if (b == 0 || (b & 64'(psz - 1)) != 0) exp_err = 1'b1;
            else begin exp_addr[exp_n] = b; exp_len[exp_n] = rem; exp_n++; end
            return;
        end
        if (b == 0) begin exp_err = 1'b1; return; end
        la = b;
        more = 1'b1;
        while (more) begin
            cnt = (rem + psz - 1) / psz;
            if (cnt > epp) cnt = epp;
            exp_rq_addr[exp_rq] = la; exp_rq_cnt[exp_rq] = cnt; exp_rq++;
            more = 1'b0;
            i = 0;
            while (rem != 0) begin
                e = mem[idx(la + 64'(8 * i))];
                if (e == 0 || (e & 64'(psz - 1)) != 0) begin exp_err = 1'b1; return; end
                if (i == epp - 1 && rem > psz) begin la = e; more = 1'b1; break; end
                l = (rem < psz) ? rem : psz;
                exp_addr[exp_n] = e; exp_len[exp_n] = l; exp_n++;
                rem -= l;
                i++;
            end
        end
    endtask

    task automatic run_case(input logic [63:0] a, input logic [63:0] b, input int len,
                            input int sel, input string etag);
        int guard = 0;
        int nmin;
        ref_walk(a, b, len, sel);
        got_n = 0; got_rq = 0; got_done = 1'b0; got_err = 1'b0; got_nr = 1'b0;
        @(negedge clk);
        ptr_first = a; ptr_second = b; xfer_bytes = 32'(len); page_sel = 4'(sel);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got_done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(got_done, "R10 done pulse seen", 64'(got_done), 64'd1);
        chk(got_err == exp_err, etag, 64'(got_err), 64'(exp_err));
        chk(got_nr == exp_err, "R2 no-retry flag matches error", 64'(got_nr), 64'(exp_err));
        chk(got_n == exp_n, "R5 segment count", 64'(got_n), 64'(exp_n));
        nmin = (got_n < exp_n) ? got_n : exp_n;
        for (int i = 0; i < nmin; i++) begin
            chk(got_addr[i] == exp_addr[i], (i == 0) ? "R1 head addr" : "R3/R5 segment addr",
                got_addr[i], exp_addr[i]);
            chk(got_len[i] == exp_len[i], (i == 0) ? "R1/R8 head len" : "R3/R5/R8 segment len",
                64'(got_len[i]), 64'(exp_len[i]));
        end
        chk(got_rq == exp_rq, "R4/R6 request count", 64'(got_rq), 64'(exp_rq));
        nmin = (got_rq < exp_rq) ? got_rq : exp_rq;
        for (int i = 0; i < nmin; i++) begin
            chk(got_rq_addr[i] == exp_rq_addr[i], (i == 0) ? "R4 list addr" : "R6 chain addr",
                got_rq_addr[i], exp_rq_addr[i]);
            chk(got_rq_cnt[i] == exp_rq_cnt[i], (i == 0) ? "R4 word count" : "R6 chained word count",
                64'(got_rq_cnt[i]), 64'(exp_rq_cnt[i]));
        end
        chk(pend_n == 0, "R7 response beats drained", 64'(pend_n), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int psz;
        int offs [4];
        repeat (4) @(negedge clk);
        // R10: quiet while in and just after reset
        chk(!seg_valid && !rd_req_valid && !done, "R10 reset quiet",
            {61'd0, seg_valid, rd_req_valid, done}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!seg_valid && !rd_req_valid && !done, "R10 idle quiet",
            {61'd0, seg_valid, rd_req_valid, done}, 64'd0);

        // sweeps: page size, head offset, length
        for (int sel = 0; sel < 3; sel++) begin
            psz = 1 << (BS + sel);
            fill_mem(sel);
            bp_on = (sel == 1);
            offs[0] = 0; offs[1] = 1; offs[2] = psz / 2; offs[3] = psz - 8;
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 25; k++)
                    run_case(64'h8000_0000_0000 + 64'(offs[o]), 64'h1000,
                             1 + k * psz * 3 / 4, sel, "R1/R3/R5 status");
        end

        // targeted errors, 32-byte page, 4 slots
        bp_on = 1'b0;
        fill_mem(0);
        run_case(64'h0, 64'h1000, 100, 0, "R2 zero first pointer");
        run_case(64'h200, 64'h0, 40, 0, "R3 zero direct pointer");
        run_case(64'h200, 64'h1004, 40, 0, "R3 misaligned direct pointer");
        run_case(64'h200, 64'h0, 200, 0, "R4 zero list address");
        mem[idx(64'h1008)] = 64'h0;
        run_case(64'h200, 64'h1000, 192, 0, "R7 zero entry mid burst");
        fill_mem(0);
        mem[idx(64'h1018)] = 64'h1203;
        run_case(64'h200, 64'h1000, 352, 0, "R7 misaligned chain pointer");
        fill_mem(0);
        mem[idx(64'h1200)] = 64'h40_0000_0004;
        run_case(64'h200, 64'h1000, 352, 0, "R7 misaligned chained entry");
        fill_mem(0);
        run_case(64'h210, 64'h1000, 352, 0, "R6 clean walk after errors");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule